// File: doc/BRIEF.md
# Multi-Supply Reset Sequencer

This block turns a set of synchronous "supply above threshold" flags, one per monitored rail and each produced by an external comparator, into a system reset. The reset is driven as a complementary pair: an active-low line and an active-high line. Reset is raised as soon as any monitored rail is low. It is dropped only after every monitored rail has stayed good for a hold period. That period is set as a parameter in clock cycles.

A push-button controller can also raise reset through a hard-reset request input. While the request is high, the hold counter stays at zero. The hold period starts counting only once the request has been removed and every enabled rail is good.

A per-channel enable mask removes unused rails from monitoring, so the same block can watch one, two or three supplies. The flags and the request first pass through two-stage synchronizers. A status bit, `supply_fault_o`, reports whether any enabled rail is currently low.

Top module: `rsq_reset_sequencer`

## Requirements
- R1: When any enabled supply flag is low (0 means below threshold), `sys_rst_o` is 1 and `sys_rst_n_o` is 0 from the second clock edge after the flag falls.
- R2: Once every enabled flag is 1 and the request is 0, reset stays asserted for exactly HOLD_CYCLES further edges beyond the two synchronizer edges. It is released on edge HOLD_CYCLES+2 after the last bad input.
- R3: A brownout on any enabled channel, even one cycle long and occurring partway through the hold period, clears the count. The full period then restarts from the moment the rail recovers.
- R4: `sys_rst_o` is always the logical inverse of `sys_rst_n_o`.
- R5: While `hard_req_i` is 1, reset stays asserted and the count stays at zero, whatever the supplies are doing. Release follows HOLD_CYCLES+2 edges after the request falls.
- R6: A channel whose bit in `chan_en_i` is 0 is ignored. A low flag on that channel neither asserts reset nor raises `supply_fault_o`.
- R7: The hold counter saturates at its terminal count. After release, reset stays released for as long as the inputs remain good, with no wrap.
- R8: While `rst_n` is 0, reset is asserted. After `rst_n` rises with all supplies good, release takes the full HOLD_CYCLES+2 edges.
- R9: `supply_fault_o` is 1 exactly when some enabled synchronized flag is 0. It follows its input two edges later and does not reflect `hard_req_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok_i | input | NUM_SUPPLIES | Per-rail comparator flag, 1 = above threshold |
| chan_en_i | input | NUM_SUPPLIES | Per-rail monitor enable, 1 = monitored |
| hard_req_i | input | 1 | Hard-reset request from push-button logic, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| supply_fault_o | output | 1 | Any enabled rail currently low |

## Verification
The assertions assume that `chan_en_i` is quasi-static. It is not synchronized, so the bench changes it only while reset is already asserted or while every flag is good, and never in the same cycle as a flag edge. The assertions also assume that inputs change at most once per clock. The bench therefore drives every input on the falling edge and holds each value for at least one full cycle. Under these two assumptions the two-stage synchronizer delay is an exact, fixed latency, which both the assertions and the arithmetic expectations in the bench depend on.

// File: rtl/rsq_pkg.sv
// Package: shared constants and helpers for the reset sequencer.
// Assumes: hold period is at least one cycle.
package rsq_pkg;

    // Default synchronizer depth for all asynchronous flags.
    localparam int unsigned RSQ_SYNC_STAGES = 2;

    // Width of a counter that must hold values 0..limit inclusive.
    function automatic int unsigned rsq_cnt_width(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
// Module: multi-bit flop chain synchronizer, one independent chain per bit.
// Assumes: each bit changes at most once per clock; bits are unrelated.
module rsq_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = rsq_pkg::RSQ_SYNC_STAGES,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw input into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= {WIDTH{RST_VAL}};
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Purpose: shift the value one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/rsq_fault_qual.sv
// Module: masks the synchronized supply flags with the channel enables and
// reduces them to a single fault bit.
// Assumes: flags are already synchronous; enables are quasi-static.
module rsq_fault_qual #(
    parameter int unsigned NUM_SUPPLIES = 3
) (
    input  logic [NUM_SUPPLIES-1:0] ok_s_i,
    input  logic [NUM_SUPPLIES-1:0] en_i,
    output logic                    fault_o
);
    logic [NUM_SUPPLIES-1:0] low_vec;

    genvar c;
    generate
        for (c = 0; c < NUM_SUPPLIES; c++) begin : g_chan
            // A channel reports low only when it is monitored.
            assign low_vec[c] = en_i[c] & ~ok_s_i[c];
        end
    endgenerate

    // Purpose: any monitored channel below threshold counts as a fault.
    always_comb begin
        fault_o = |low_vec;
    end

endmodule

// File: rtl/rsq_hold_timer.sv
// Module: saturating hold counter. It is cleared whenever clear_i is high,
// counts up otherwise and stops at HOLD_CYCLES, where done_o rises.
// Assumes: HOLD_CYCLES >= 1.
module rsq_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic done_o
);
    localparam int unsigned CW = rsq_pkg::rsq_cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] TERM = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] TERM_M1 = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_term;

    assign at_term = (cnt_q == TERM);

    // Purpose: clear on request, count while quiet, stop at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (!at_term) cnt_q <= cnt_q + CW'(1);
    end

    assign done_o = at_term;

    // R7: the counter never passes its terminal count.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);

    // R7: once at terminal count and not cleared, it stays there.
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (at_term && !clear_i) |=> at_term);

    // R3 / R5: a clear request always leaves the count at zero.
    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R2: done can only rise from one below terminal with no clear.
    a_r2_full_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cnt_q) == TERM_M1 && !$past(clear_i)));

endmodule

// File: rtl/rsq_reset_sequencer.sv
// Module: top of the multi-supply reset sequencer. It synchronizes the rail
// flags and the hard-reset request, qualifies the flags with the enable mask,
// and holds system reset until the hold timer has run a full clean period.
// Assumes: chan_en_i is quasi-static; inputs change at most once per clock.
module rsq_reset_sequencer #(
    parameter int unsigned NUM_SUPPLIES = 3,
    parameter int unsigned HOLD_CYCLES  = 1000,
    parameter int unsigned SYNC_STAGES  = rsq_pkg::RSQ_SYNC_STAGES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SUPPLIES-1:0] supply_ok_i,
    input  logic [NUM_SUPPLIES-1:0] chan_en_i,
    input  logic                    hard_req_i,
    output logic                    sys_rst_n_o,
    output logic                    sys_rst_o,
    output logic                    supply_fault_o
);
    logic [NUM_SUPPLIES-1:0] ok_s;
    logic                    req_s;
    logic                    fault;
    logic                    hold_done;
    logic                    rst_active;

    // Rail flags reset to "not ok", so reset starts asserted.
    rsq_sync #(
        .WIDTH  (NUM_SUPPLIES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync_ok (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (supply_ok_i),
        .q_o  (ok_s)
    );

    rsq_sync #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync_req (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (hard_req_i),
        .q_o  (req_s)
    );

    rsq_fault_qual #(
        .NUM_SUPPLIES(NUM_SUPPLIES)
    ) u_qual (
        .ok_s_i (ok_s),
        .en_i   (chan_en_i),
        .fault_o(fault)
    );

    rsq_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(fault | req_s),
        .done_o (hold_done)
    );

    // Purpose: reset is active on a live fault, a live request or an unexpired hold.
    always_comb begin
        rst_active = fault | req_s | ~hold_done;
    end

    assign sys_rst_o      = rst_active;
    assign sys_rst_n_o    = ~rst_active;
    assign supply_fault_o = fault;

    // R2: release only follows a cycle with no fault and no request.
    a_r2_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> ($past(!supply_fault_o) && $past(!req_s)));

    // R1: a synchronized fault means the timer is not done on the next cycle.
    a_r1_fault_blocks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault_o |=> !hold_done);

    // R5: a synchronized request means the timer is not done on the next cycle.
    a_r5_req_blocks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        req_s |=> !hold_done);

endmodule

// File: tb/rsq_reset_sequencer_tb.sv
`timescale 1ns/1ps
module rsq_reset_sequencer_tb;
    localparam int N    = 3;
    localparam int HOLD = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ok = '0;
    logic [N-1:0] en = '1;
    logic         req = 1'b0;
    logic         rst_n_o, rst_o, fault_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rsq_reset_sequencer #(
        .NUM_SUPPLIES(N),
        .HOLD_CYCLES (HOLD)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_i   (ok),
        .chan_en_i     (en),
        .hard_req_i    (req),
        .sys_rst_n_o   (rst_n_o),
        .sys_rst_o     (rst_o),
        .supply_fault_o(fault_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance n rising edges, ending on a falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_rst(input string tag, input bit exp_active);
        check(tag, {31'b0, rst_o}, {31'b0, exp_active});
        check({tag, "/R4"}, {31'b0, rst_n_o}, {31'b0, ~exp_active});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(3);
        // R8: reset asserted while block reset is held.
        check_rst("R8 reset state", 1'b1);
        ok = '1;
        en = '1;
        rst_n = 1'b1;
        step(HOLD + 1);
        check_rst("R8 full period after reset", 1'b1);
        step(1);
        check_rst("R8 release after reset", 1'b0);

        // Exhaustive sweep over enable masks and supply patterns.
        for (int m = 0; m < (1 << N); m++) begin
            for (int p = 0; p < (1 << N); p++) begin
                logic [N-1:0] mask, pat;
                bit exp_fault;
                mask = N'(m);
                pat  = N'(p);
                en = mask;
                ok = '1;
                step(HOLD + 4);
                check_rst("R2 steady released", 1'b0);
                exp_fault = |(mask & ~pat);
                ok = pat;
                step(1);
                check("R9 latency", {31'b0, fault_o}, 32'd0);
                step(1);
                check("R9 fault flag", {31'b0, fault_o}, {31'b0, exp_fault});
                if (exp_fault) begin
                    check_rst("R1 fault asserts", 1'b1);
                    ok = '1;
                    step(HOLD + 1);
                    check_rst("R2 still holding", 1'b1);
                    step(1);
                    check_rst("R2 release", 1'b0);
                end else begin
                    // R6: disabled low channels have no effect.
                    check_rst("R6 ignored channel", 1'b0);
                    step(1);
                    check_rst("R6 ignored channel later", 1'b0);
                    ok = '1;
                end
            end
        end

        // R3: one-cycle brownout mid-count restarts the whole period.
        en = '1;
        ok = '1;
        step(HOLD + 4);
        ok = 3'b101;
        step(1);
        ok = '1;
        step(HOLD / 2);
        ok = 3'b011;
        step(1);
        ok = '1;
        step(HOLD + 1);
        check_rst("R3 restarted period", 1'b1);
        step(1);
        check_rst("R3 release after restart", 1'b0);

        // R5: hard request holds reset regardless of supplies.
        req = 1'b1;
        step(2);
        check_rst("R5 request asserts", 1'b1);
        check("R9 request not a fault", {31'b0, fault_o}, 32'd0);
        step(3 * HOLD);
        check_rst("R5 held during request", 1'b1);
        req = 1'b0;
        step(HOLD + 1);
        check_rst("R5 counting after request", 1'b1);
        step(1);
        check_rst("R5 release after request", 1'b0);

        // R5: request overlapping a fault; release timed from request removal.
        ok = 3'b110;
        req = 1'b1;
        step(3);
        ok = '1;
        step(2 * HOLD);
        check_rst("R5 request outlasts fault", 1'b1);
        req = 1'b0;
        step(HOLD + 1);
        check_rst("R5 overlap holding", 1'b1);
        step(1);
        check_rst("R5 overlap release", 1'b0);

        // R7: saturation, no wrap over many periods.
        for (int i = 0; i < 4 * HOLD; i++) begin
            step(1);
            check_rst("R7 stays released", 1'b0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule